// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block holds received UART characters in a 64-deep queue. Each entry keeps the character and three error flags: break, framing error (no valid stop bit) and parity error. A status byte sits beside the queue. It reports whether data is waiting and whether an overrun happened. It shows the error flags of the oldest queued character, and it carries a summary flag that stays set while any flagged character is still queued. It also passes through the two transmit-empty conditions that come from outside the block.

A receiver pulses `rx_push` for one cycle with the character and its flags. The host inspects `lsr` before it pulses `rhr_rd`, which pops the character shown on `rhr_data`. A pulse on `lsr_rd` marks a status read, and that read clears the overrun flag. Both outputs are combinational views of the registered state, so a pop or push shows on the outputs from the clock edge on which it happens.

Top module: `uart_rx_status_fifo`

## Requirements
- R1: `lsr[0]` is 1 exactly when the queue holds at least one character.
- R2: Characters leave the queue in arrival order. The queue holds up to 64 characters, and `rhr_data` always shows the oldest one. A push and a pop in the same cycle are both honoured, even when the queue is full.
- R3: `lsr[4]` (break), `lsr[3]` (framing) and `lsr[2]` (parity) show the flags stored with the oldest queued character. They are 0 when the queue is empty.
- R4: `lsr[7]` is 1 while at least one queued character carries a break, framing or parity flag. It is 0 otherwise.
- R5: A character pushed with its break flag set is stored and read back as 0x00, whatever value `rx_data` had.
- R6: A push while the queue is full and no pop happens in that cycle is discarded and sets `lsr[1]`. `lsr[1]` clears on the edge after an `lsr_rd` pulse, unless a new overrun happens in that same cycle, in which case it stays set.
- R7: `rhr_rd` with an empty queue changes no state, and `rhr_data` reads 0x00 while the queue is empty.
- R8: `lsr[5]` equals `thr_empty`, and `lsr[6]` equals `thr_empty & tsr_empty`.
- R9: After reset the queue is empty, and the overrun flag and the error count are zero. Every `lsr` bit except 6:5 reads 0, and `rhr_data` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | One-cycle strobe: a received character is presented |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break flag of the presented character |
| rx_frm | input | 1 | Framing error flag of the presented character |
| rx_par | input | 1 | Parity error flag of the presented character |
| rhr_rd | input | 1 | Host read of the holding register; pops one character |
| lsr_rd | input | 1 | Host read of the status byte; clears overrun |
| thr_empty | input | 1 | Transmit holding register/queue is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| rhr_data | output | 8 | Oldest queued character, 0x00 when empty |
| lsr | output | 8 | Line status byte |

## Verification
The first directed runs push only clean characters in short bursts, which tests ordering and data-ready in isolation. They are followed by mixes in which flagged and clean characters alternate. These separate the head-only flags in bits 4:2 from the summary in bit 7, because the summary must stay set while a clean character sits at the head. A fill to 64 entries followed by extra pushes, with and without a pop in the same cycle, checks when a character is accepted and when it is discarded. It also checks how the overrun flag responds to a status read in the same cycle. A long random phase with biased push and read rates keeps the queue near full and near empty, and a behavioural queue model is compared with the outputs on every cycle.

// File: rtl/uart_rx_status_fifo.sv
module uart_rx_status_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_brk,
  input  logic          rx_frm,
  input  logic          rx_par,
  input  logic          rhr_rd,
  input  logic          lsr_rd,
  input  logic          thr_empty,
  input  logic          tsr_empty,
  output logic [DW-1:0] rhr_data,
  output logic [7:0]    lsr
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DW + 3;
  localparam logic [AW:0]   FULLC = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, ecnt;
  logic          ovr;

  wire          empty    = (cnt == '0);
  wire          full     = (cnt == FULLC);
  wire          pop      = rhr_rd & ~empty;
  wire          push_ok  = rx_push & (~full | pop);
  wire          in_bad   = rx_brk | rx_frm | rx_par;
  wire [EW-1:0] head     = empty ? '0 : mem[rp];
  wire          head_bad = |head[EW-1:DW];
  wire [EW-1:0] entry    = {rx_brk, rx_frm, rx_par, rx_brk ? {DW{1'b0}} : rx_data};

  always_ff @(posedge clk)
    if (push_ok) mem[wp] <= entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ecnt <= '0;
      ovr  <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      cnt  <= cnt + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop};
      ecnt <= ecnt + {{AW{1'b0}}, push_ok & in_bad} - {{AW{1'b0}}, pop & head_bad};
      if (rx_push && !push_ok) ovr <= 1'b1;
      else if (lsr_rd)         ovr <= 1'b0;
    end
  end

  assign rhr_data = head[DW-1:0];
  assign lsr = {ecnt != '0, thr_empty & tsr_empty, thr_empty,
                head[EW-1], head[EW-2], head[EW-3], ovr, ~empty};
endmodule

module uart_rx_status_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_push,
  input logic       rhr_rd,
  input logic       lsr_rd,
  input logic [7:0] rhr_data,
  input logic [7:0] lsr
);
  // R1
  push_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rhr_rd |=> lsr[0]);
  // R4
  head_err_implies_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[7] |-> lsr[4:2] == 3'b000);
  // R5
  break_char_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[4] |-> rhr_data == 8'h00);
  // R6
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !rx_push |=> !lsr[1]);
  // R6
  overrun_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[1] && !rx_push |=> !lsr[1]);
  // R7
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr[0] |-> rhr_data == 8'h00);
  // R8
  tx_empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
endmodule

bind uart_rx_status_fifo uart_rx_status_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rhr_rd(rhr_rd),
  .lsr_rd(lsr_rd), .rhr_data(rhr_data), .lsr(lsr)
);

// File: tb/uart_rx_status_fifo_tb.sv
`timescale 1ns/1ps
module uart_rx_status_fifo_tb;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_push = 0, rx_brk = 0, rx_frm = 0, rx_par = 0;
  logic rhr_rd = 0, lsr_rd = 0, thr_empty = 0, tsr_empty = 0;
  logic [7:0] rx_data = 0, rhr_data, lsr;

  int checks = 0, errors = 0;
  logic [10:0] q[$];
  bit ovr = 0;

  always #2 clk = ~clk;

  uart_rx_status_fifo u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int nerr = 0;
    logic [10:0] h;
    foreach (q[i]) if (q[i][10:8] != 0) nerr++;
    h = (q.size() > 0) ? q[0] : 11'h0;
    chk(lsr[0] == (q.size() > 0), "R1", lsr[0], q.size() > 0);
    chk(rhr_data == h[7:0], h[10] ? "R5" : (q.size() == 0 ? "R7" : "R2"), rhr_data, h[7:0]);
    chk(lsr[4:2] == h[10:8], "R3", lsr[4:2], h[10:8]);
    chk(lsr[7] == (nerr > 0), "R4", lsr[7], nerr > 0);
    chk(lsr[1] == ovr, "R6", lsr[1], ovr);
    chk(lsr[6:5] == {thr_empty & tsr_empty, thr_empty}, "R8", lsr[6:5],
        {thr_empty & tsr_empty, thr_empty});
  endtask

  task automatic step(input bit p, input logic [7:0] d, input bit b, input bit f,
                      input bit pa, input bit rd, input bit lr, input bit te, input bit se);
    bit pop, acc;
    @(negedge clk);
    rx_push = p; rx_data = d; rx_brk = b; rx_frm = f; rx_par = pa;
    rhr_rd = rd; lsr_rd = lr; thr_empty = te; tsr_empty = se;
    #1 compare();
    @(posedge clk);
    pop = rd && q.size() > 0;
    acc = p && (q.size() < DEPTH || pop);
    if (pop) void'(q.pop_front());
    if (acc) q.push_back({b, f, pa, b ? 8'h00 : d});
    if (p && !acc) ovr = 1;
    else if (lr) ovr = 0;
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    thr_empty = 1; tsr_empty = 0;
    #1;
    // R9 reset state
    chk(lsr == 8'h20, "R9", lsr, 8'h20);
    chk(rhr_data == 8'h00, "R9", rhr_data, 0);
    rst_n = 1;
    // R7: read of empty queue
    step(0, 0, 0, 0, 0, 1, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R1 R2: clean burst, then drain
    for (int i = 0; i < 5; i++) step(1, 8'h41 + i, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 0, 1, 0);
    // R3 R4 R5: flagged mixed with clean
    step(1, 8'h10, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'hA5, 1, 0, 0, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0, 0, 0, 0);
    step(1, 8'h33, 0, 1, 0, 0, 0, 0, 0);
    step(1, 8'h44, 0, 0, 1, 0, 0, 0, 0);
    step(1, 8'h55, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 0, 1, 1, 1, 1);
    // R6: fill to full, overflow, status read, same-cycle push+pop
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 0, 0, i == 63, 0, 0, 0, 1);
    step(1, 8'hEE, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1);
    step(1, 8'hEF, 0, 1, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 8'hF0, 0, 0, 0, 1, 1, 0, 1);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 0, 1, 0, 1, 1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int bias = (i / 500) % 3;
      step(($urandom % 4) < (bias == 0 ? 3 : (bias == 1 ? 2 : 1)), 8'($urandom),
           ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
           ($urandom % 4) < (bias == 2 ? 3 : 1), ($urandom % 16) == 0,
           1'($urandom), 1'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule